// File: doc/BRIEF.md
# Serial Control and Status Shifter

This block is the serial front end of a six-channel half-bridge driver controller. A host selects the block by pulling an active-low select low. It then clocks a 16-bit control word in, least significant bit first. In the same transfer, a 16-bit status word comes back on a tri-stated data output. All four serial pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the serial clock edges are found in the system clock domain. For this to work, the system clock must be at least eight times the serial clock.

The received word is applied only when the select returns high, and only if the count of serial clocks was a non-zero multiple of 16. When more than 16 bits arrive, the last 16 are kept, and the earlier bits leave on the data output after the status bits, so several blocks can be chained. As soon as the block is selected, status bit 0 (temperature prewarning) is on the output, before any clock edge. A host can read that bit and deselect at once without disturbing anything.

The control word and its load strobe form a valid-only stream toward the protection logic. The strobe is the valid, and there is no ready: the consumer must accept the word in the cycle the strobe is high, and the block never stalls. The status word is a plain parallel input. It is captured when a transfer starts.

Top module: `serial_ctrl_status_if`

## Requirements
- R1: After reset, `ctrl_word` is 16'hE000 (bits 15, 14 and 13 high, all others low), `ctrl_load` and `status_clear` are low, and `sdo_oe` is low.
- R2: While the synchronised select is high, `sdo_oe` is low and `sdo` is high impedance. While it is low, `sdo_oe` is high.
- R3: Within 4 system cycles of the select falling, with no serial clock edge, `sdo` shows bit 0 of the status word.
- R4: The status word leaves least significant bit first. After k falling serial clock edges of a transfer, the next rising edge puts status bit k on `sdo`, and it stays there until the following rising edge. The first rising edge of a transfer leaves bit 0 in place.
- R5: `sdi` is sampled on falling serial clock edges. The i-th bit sampled (counting from 0) of the last 16 becomes bit i of the committed word.
- R6: `ctrl_word` changes only on the select's rising edge, together with a single-cycle `ctrl_load` pulse. During a transfer it keeps its previous value.
- R7: A transfer whose falling-clock count is zero or not a multiple of 16 produces no `ctrl_load`, and `ctrl_word` is unchanged.
- R8: When a transfer has more than 16 falling clocks, `sdo` continues after the 16 status bits with the received bits in arrival order, so that output bit k equals input bit k-16.
- R9: `status_clear` is a one-cycle pulse, issued together with `ctrl_load`, exactly when bit 0 of the committed word is 1. It never occurs at any other time.
- R10: The status word is captured when the select falls. Changes on `status_in` during the transfer do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low select |
| sck | input | 1 | Asynchronous serial clock, idles low |
| sdi | input | 1 | Asynchronous serial data in |
| sdo | output | 1 | Serial data out, high impedance when not selected |
| sdo_oe | output | 1 | Output enable of `sdo` |
| status_in | input | 16 | Parallel status word from protection logic |
| ctrl_word | output | 16 | Last committed control word |
| ctrl_load | output | 1 | One-cycle valid strobe for a new `ctrl_word` |
| status_clear | output | 1 | One-cycle pulse when a committed word has bit 0 set |

## Verification
A wrong bit counter shows up in two ways: a commit after an aborted or odd-length transfer, or a missing commit after a full one. Either is visible on `ctrl_load` within a few system cycles of deselect. A misaligned transmit register gives a wrong bit on `sdo` at the first rising serial clock it affects, or already at the select peek. A slipped receive register, or a wrong choice of which 16 bits survive a long transfer, appears as a wrong `ctrl_word` at the next commit. In every case the error is visible no later than the end of the transfer that caused it.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int unsigned SCS_WORD_W = 16;
  // Power-on value: software enable, long short-circuit delay, open-load detection off
  localparam logic [SCS_WORD_W-1:0] SCS_CTRL_RST = 16'hE000;
  // The status-clear request sits in bit 0 of the control word
  localparam int unsigned SCS_CLR_BIT = 0;

  typedef struct packed {
    logic sel_start;
    logic sel_end;
    logic sck_rise;
    logic sck_fall;
  } scs_events_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= RST_VAL[g];
        stable_q <= RST_VAL[g];
      end else begin
        meta_q   <= async_in[g];
        stable_q <= meta_q;
      end
    end
    assign sync_out[g] = stable_q;
  end
endmodule

// File: rtl/scs_edge.sv
module scs_edge
  import scs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_s,
  input  logic        sck_s,
  output scs_events_t ev
);
  logic cs_n_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      cs_n_q <= cs_n_s;
      sck_q  <= sck_s;
    end
  end

  always_comb begin
    ev.sel_start = cs_n_q & ~cs_n_s;
    ev.sel_end   = ~cs_n_q & cs_n_s;
    ev.sck_rise  = ~cs_n_s & ~sck_q & sck_s;
    ev.sck_fall  = ~cs_n_s & sck_q & ~sck_s;
  end
endmodule

// File: rtl/scs_shift_core.sv
module scs_shift_core
  import scs_pkg::*;
#(
  parameter int unsigned W = SCS_WORD_W,
  parameter logic [W-1:0] CTRL_RST = SCS_CTRL_RST,
  parameter int unsigned CLR_BIT = SCS_CLR_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  scs_events_t  ev,
  input  logic         di_s,
  input  logic [W-1:0] status_in,
  output logic         tx_bit,
  output logic         active,
  output logic [W-1:0] ctrl_word,
  output logic         ctrl_load,
  output logic         status_clear
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [W-1:0]     rx_q, tx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrapped_q, pend_q, last_di_q;
  logic             word_ok;

  assign word_ok = wrapped_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q         <= '0;
      tx_q         <= '0;
      cnt_q        <= '0;
      wrapped_q    <= 1'b0;
      pend_q       <= 1'b0;
      last_di_q    <= 1'b0;
      active       <= 1'b0;
      ctrl_word    <= CTRL_RST;
      ctrl_load    <= 1'b0;
      status_clear <= 1'b0;
    end else begin
      ctrl_load    <= 1'b0;
      status_clear <= 1'b0;
      if (ev.sel_start) begin
        tx_q      <= status_in;
        cnt_q     <= '0;
        wrapped_q <= 1'b0;
        pend_q    <= 1'b0;
        active    <= 1'b1;
      end else if (ev.sel_end) begin
        active <= 1'b0;
        if (word_ok) begin
          ctrl_word    <= rx_q;
          ctrl_load    <= 1'b1;
          status_clear <= rx_q[CLR_BIT];
        end
      end else if (active) begin
        if (ev.sck_fall) begin
          rx_q      <= {di_s, rx_q[W-1:1]};
          last_di_q <= di_s;
          pend_q    <= 1'b1;
          if (cnt_q == CNT_LAST) begin
            cnt_q     <= '0;
            wrapped_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (ev.sck_rise && pend_q) begin
          tx_q   <= {last_di_q, tx_q[W-1:1]};
          pend_q <= 1'b0;
        end
      end
    end
  end

  assign tx_bit = tx_q[0];
endmodule

// File: rtl/serial_ctrl_status_if.sv
module serial_ctrl_status_if
  import scs_pkg::*;
#(
  parameter int unsigned WORD_W = SCS_WORD_W,
  parameter logic [WORD_W-1:0] CTRL_RST = SCS_CTRL_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [WORD_W-1:0] status_in,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              ctrl_load,
  output logic              status_clear
);
  localparam logic [2:0] PIN_IDLE = 3'b001;

  logic [2:0]  pins_s;
  scs_events_t ev;
  logic        tx_bit;

  scs_sync #(.W(3), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sdi, sck, cs_n}), .sync_out(pins_s)
  );

  scs_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[0]), .sck_s(pins_s[1]), .ev(ev)
  );

  scs_shift_core #(.W(WORD_W), .CTRL_RST(CTRL_RST), .CLR_BIT(SCS_CLR_BIT)) u_core (
    .clk(clk), .rst_n(rst_n), .ev(ev), .di_s(pins_s[2]),
    .status_in(status_in), .tx_bit(tx_bit), .active(sdo_oe),
    .ctrl_word(ctrl_word), .ctrl_load(ctrl_load), .status_clear(status_clear)
  );

  assign sdo = sdo_oe ? tx_bit : 1'bz;
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sdo,
  input logic         sdo_oe,
  input logic [W-1:0] status_in,
  input logic [W-1:0] ctrl_word,
  input logic         ctrl_load,
  input logic         status_clear
);
  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> !ctrl_load);

  assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |-> $stable(ctrl_word));

  assert_load_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |-> !sdo_oe);

  assert_clear_with_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_clear |-> (ctrl_load && ctrl_word[0]));

  assert_peek_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == $past(status_in[0])));
endmodule

bind serial_ctrl_status_if scs_checker #(.W(WORD_W)) u_scs_checker (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in),
  .ctrl_word(ctrl_word), .ctrl_load(ctrl_load), .status_clear(status_clear)
);

// File: tb/test_serial_ctrl_status_if.sv
`timescale 1ns/1ps
module test_serial_ctrl_status_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, ctrl_load, status_clear;
  logic [15:0] status_in = '0;
  logic [15:0] ctrl_word;

  int checks = 0, errors = 0, n_load = 0, n_clear = 0;
  logic [15:0] exp_ctrl = 16'hE000;
  bit done = 0;

  always #2 clk = ~clk;

  serial_ctrl_status_if i_serial_ctrl_status_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in),
    .ctrl_word(ctrl_word), .ctrl_load(ctrl_load), .status_clear(status_clear)
  );

  always @(posedge clk) begin
    if (ctrl_load) n_load++;
    if (status_clear) n_clear++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] commit_word(input int nbits, input logic [63:0] d);
    return d[nbits-16 +: 16];
  endfunction

  // One transfer: nbits serial clocks, then deselect; checks every output bit and the commit.
  task automatic xfer(input logic [15:0] st, input int nbits, input logic [63:0] d);
    int ld0 = n_load, cl0 = n_clear;
    bit commit = (nbits > 0) && (nbits % 16 == 0);
    status_in = st;
    cs_n = 1'b0;
    wcyc(6);
    chk("R2 oe", 32'(sdo_oe), 32'd1);
    chk("R3 peek", 32'(sdo), 32'(st[0]));
    status_in = ~st; // R10: changes after capture must not reach sdo
    for (int j = 0; j < nbits; j++) begin
      sdi = d[j];
      wcyc(4);
      sck = 1'b1;
      wcyc(8);
      if (j < 16) chk("R4/R10 status bit", 32'(sdo), 32'(st[j]));
      else        chk("R8 chained bit", 32'(sdo), 32'(d[j-16]));
      sck = 1'b0;
      wcyc(4);
    end
    wcyc(4);
    chk("R6 held during transfer", 32'(ctrl_word), 32'(exp_ctrl));
    cs_n = 1'b1;
    wcyc(8);
    chk("R2 oe off", 32'(sdo_oe), 32'd0);
    if (commit) begin
      exp_ctrl = commit_word(nbits, d);
      chk("R6 one load", 32'(n_load - ld0), 32'd1);
      chk("R9 clear", 32'(n_clear - cl0), 32'(exp_ctrl[0]));
    end else begin
      chk("R7 no load", 32'(n_load - ld0), 32'd0);
      chk("R7/R9 no clear", 32'(n_clear - cl0), 32'd0);
    end
    chk("R5 word", 32'(ctrl_word), 32'(exp_ctrl));
    wcyc(4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    wcyc(5);
    chk("R1 ctrl", 32'(ctrl_word), 32'h0000E000);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    wcyc(5);
    chk("R1 ctrl after", 32'(ctrl_word), 32'h0000E000);
    chk("R1 no load", 32'(n_load), 32'd0);
    chk("R2 oe idle", 32'(sdo_oe), 32'd0);
    // directed corner cases
    xfer(16'h0001, 0, 64'h0);                      // R3 peek then abort (R7)
    xfer(16'hA5C3, 16, 64'h0000_0000_0000_1234);   // R5 plain commit, clear low
    xfer(16'h5A5A, 7, 64'h0000_0000_0000_00FF);    // R7 short abort
    xfer(16'hFFFE, 16, 64'h0000_0000_0000_8001);   // R9 clear pulse
    xfer(16'h0F0F, 17, 64'h0000_0000_0001_FFFF);   // R7 one too many
    xfer(16'h1357, 32, 64'h0000_0000_BEEF_CAFE);   // R8 chain of two
    xfer(16'h2468, 48, 64'h0000_1111_2222_3333);   // R8 chain of three
    for (int t = 0; t < 30; t++) begin
      int sel = $urandom % 6;
      int len = (sel == 0) ? 16 : (sel == 1) ? 32 : (sel == 2) ? ($urandom % 48)
              : (sel == 3) ? 16 : (sel == 4) ? 15 : 48;
      xfer(16'($urandom), len, {$urandom, $urandom});
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule